// File: doc/BRIEF.md
# Ones-Complement Block Checksum Unit

This unit produces and verifies an end-around-carry checksum over a message that arrives as a stream of equal-width words. The width is 16 bits by default and is set by a parameter. The sender and the receiver must use the same width. Each accepted word is added into a running total, and any carry out of the top bit is added back into the low bits.

In generate mode, the inverted total is presented as the word to append to the message. In check mode, the stream includes the appended word. The message is accepted only when the inverted total is all zeros. That happens when the running total is all ones, the ones-complement "negative zero".

The result appears together with a one-cycle `done` pulse. The pulse comes in the cycle after the final word is accepted. A new message may begin in that same cycle.

Top module: `oc_csum_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `done` is 0, `csum_out` is all zeros and `pass` is 0.
- R2: One cycle after a beat with `in_valid`=1 and `in_last`=1, `done` is 1 for exactly one cycle. In that cycle `csum_out` is the bitwise inverse of the ones-complement sum of all words of the message.
- R3: A carry out of the top bit is added back into bit 0. With W=16, the words 0xFFFF and 0x0001 give a sum of 0x0001 and a `csum_out` of 0xFFFE.
- R4: A message of one word yields `csum_out` equal to the inverse of that word.
- R5: In check mode (`in_mode`=1 on the final beat), a message followed by its own checksum word gives `pass`=1 together with `done`.
- R6: In check mode, a message whose inverted total is not zero gives `pass`=0. This includes a single all-zero word.
- R7: In check mode, an all-ones total counts as a pass. A single word 0xFFFF gives `pass`=1 and `csum_out`=0.
- R8: Beats with `in_valid`=0 are ignored, whatever `in_word`, `in_last` and `in_mode` carry. They neither change the total nor raise `done`.
- R9: The first valid beat after a final beat starts a fresh total, even when it arrives in the same cycle that `done` is high.
- R10: In generate mode (`in_mode`=0 on the final beat), `pass` is 0 with `done`.
- R11: With W=5, the words 00110, 10001, 11001 and 10111 produce `csum_out` 10110. The same words followed by 10110 in check mode pass.
- R12: `csum_out` and `pass` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is offered this cycle |
| in_last | input | 1 | The offered word ends the message |
| in_mode | input | 1 | 0 = generate, 1 = check; sampled on the final beat |
| in_word | input | W | Message word |
| done | output | 1 | One-cycle pulse, result valid |
| csum_out | output | W | Inverted ones-complement total |
| pass | output | 1 | Check-mode verdict |

## Verification
The result of one message is presented in the same cycle that the first word of the next message clears and reloads the total. The bench provokes this by sending two messages back to back, with no idle cycle between them. It then judges the first result in the `done` cycle and the second result one cycle later. Each result is compared with a value the bench computes on its own. The second value would be wrong if the old total leaked into the new message.

// File: rtl/oc_csum_pkg.sv
package oc_csum_pkg;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } csum_mode_e;

    typedef struct packed {
        logic       valid;
        logic       last;
        csum_mode_e mode;
    } beat_ctl_t;

endpackage

// File: rtl/oc_fold_add.sv
module oc_fold_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int WX = W + 1;

    logic [WX-1:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        // end-around carry: a second carry cannot arise
        y   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/oc_accum.sv
module oc_accum
    import oc_csum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  beat_ctl_t    ctl,
    input  logic [W-1:0] word,
    output logic [W-1:0] total
);
    logic [W-1:0] acc_q;
    logic         first_q;
    logic [W-1:0] folded;

    oc_fold_add #(.W(W)) u_add (
        .a (acc_q),
        .b (word),
        .y (folded)
    );

    always_comb begin
        total = first_q ? word : folded;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            first_q <= 1'b1;
        end else if (ctl.valid) begin
            acc_q   <= total;
            first_q <= ctl.last;
        end
    end
endmodule

// File: rtl/oc_result.sv
module oc_result
    import oc_csum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  beat_ctl_t    ctl,
    input  logic [W-1:0] total,
    output logic         done,
    output logic [W-1:0] csum,
    output logic         pass
);
    logic [W-1:0] inv;
    logic         fire;
    logic         verdict;

    always_comb begin
        inv     = ~total;
        fire    = ctl.valid && ctl.last;
        verdict = (ctl.mode == MODE_CHK) && (inv == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            csum <= '0;
            pass <= 1'b0;
        end else begin
            done <= fire;
            if (fire) begin
                csum <= inv;
                pass <= verdict;
            end
        end
    end
endmodule

// File: rtl/oc_csum_unit.sv
module oc_csum_unit
    import oc_csum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_last,
    input  logic         in_mode,
    input  logic [W-1:0] in_word,
    output logic         done,
    output logic [W-1:0] csum_out,
    output logic         pass
);
    beat_ctl_t    ctl;
    logic [W-1:0] total;

    always_comb begin
        ctl.valid = in_valid;
        ctl.last  = in_last;
        ctl.mode  = csum_mode_e'(in_mode);
    end

    oc_accum #(.W(W)) u_accum (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .word  (in_word),
        .total (total)
    );

    oc_result #(.W(W)) u_result (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .total (total),
        .done  (done),
        .csum  (csum_out),
        .pass  (pass)
    );
endmodule

// File: rtl/oc_csum_unit_chk.sv
module oc_csum_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_last,
    input logic         in_mode,
    input logic [W-1:0] in_word,
    input logic         done,
    input logic [W-1:0] csum_out,
    input logic         pass
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && csum_out == '0 && !pass));

    // R2
    done_follows_last_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> done);

    // R2
    done_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid && in_last));

    // R8
    idle_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!done && $stable(csum_out) && $stable(pass)));

    // R10
    gen_no_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && !in_mode) |=> !pass);

    // R5
    check_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && in_mode) |=> (pass == (csum_out == '0)));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> ($stable(csum_out) && $stable(pass)));

    logic unused_word;
    assign unused_word = ^in_word;
endmodule

bind oc_csum_unit oc_csum_unit_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_mode  (in_mode),
    .in_word  (in_word),
    .done     (done),
    .csum_out (csum_out),
    .pass     (pass)
);

// File: tb/oc_csum_unit_bench.sv
module oc_csum_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, in_last, in_mode;
    logic [W-1:0] in_word;
    logic         done, pass;
    logic [W-1:0] csum_out;

    logic         v5, l5, m5, d5, p5;
    logic [4:0]   w5, c5;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_csum_unit #(.W(W)) u_oc_csum_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_mode(in_mode), .in_word(in_word), .done(done),
        .csum_out(csum_out), .pass(pass)
    );

    oc_csum_unit #(.W(5)) u_oc_csum_unit_w5 (
        .clk(clk), .rst(rst), .in_valid(v5), .in_last(l5),
        .in_mode(m5), .in_word(w5), .done(d5),
        .csum_out(c5), .pass(p5)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] fold(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[W-1:0] + {{(W-1){1'b0}}, s[W]};
    endfunction

    // drives words on falling edges; leaves the bus at the cycle in which done is due
    task automatic drive(input logic [W-1:0] words[8], input int n, input logic mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = words[i];
            in_last  = (i == n - 1);
            in_mode  = mode;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_word = 16'hDEAD;
    endtask

    task automatic expect_result(input string req, input logic [W-1:0] exp_c, input logic exp_p);
        check({req, " done"}, 32'(done), 32'd1);
        check({req, " csum"}, 32'(csum_out), 32'(exp_c));
        check({req, " pass"}, 32'(pass), 32'(exp_p));
        @(negedge clk);
        check({req, " done pulse ends"}, 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        // R1
        check("R1 done", 32'(done), 32'd0);
        check("R1 csum", 32'(csum_out), 32'd0);
        check("R1 pass", 32'(pass), 32'd0);
    endtask

    task automatic t_multi_gen();
        logic [W-1:0] m[8] = '{16'h4500, 16'h0073, 16'h0000, 16'h4000, 16'h4011, 16'hC0A8, 16'h0001, 16'hC0A8};
        logic [W-1:0] s = '0;
        for (int i = 0; i < 8; i++) s = fold(s, m[i]);
        drive(m, 8, 1'b0);
        // R2, R10
        expect_result("R2/R10 gen", ~s, 1'b0);
        // R5: append checksum and verify
        m[0] = 16'h4500; m[1] = 16'h0073; m[2] = 16'h0000; m[3] = 16'h4000;
        m[4] = 16'h4011; m[5] = 16'hC0A8; m[6] = 16'h0001; m[7] = 16'hC0A8;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_word = m[i]; in_last = 1'b0; in_mode = 1'b1;
        end
        @(negedge clk);
        in_word = ~s; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        expect_result("R5 check pass", 16'h0000, 1'b1);
    endtask

    task automatic t_carry();
        logic [W-1:0] m[8] = '{16'hFFFF, 16'h0001, 0, 0, 0, 0, 0, 0};
        drive(m, 2, 1'b0);
        // R3
        expect_result("R3 carry", 16'hFFFE, 1'b0);
    endtask

    task automatic t_single();
        logic [W-1:0] m[8] = '{16'h1234, 0, 0, 0, 0, 0, 0, 0};
        drive(m, 1, 1'b0);
        // R4
        expect_result("R4 single", 16'hEDCB, 1'b0);
        m[0] = 16'hFFFF;
        drive(m, 1, 1'b1);
        // R7
        expect_result("R7 negzero", 16'h0000, 1'b1);
        m[0] = 16'h0000;
        drive(m, 1, 1'b1);
        // R6
        expect_result("R6 zero word", 16'hFFFF, 1'b0);
    endtask

    task automatic t_corrupt();
        logic [W-1:0] m[8] = '{16'h1234, 16'hABCD, 16'h41FE, 0, 0, 0, 0, 0};
        m[1] = 16'hABCC;
        drive(m, 3, 1'b1);
        // R6: total 0xFFFE -> inverse 0x0001
        expect_result("R6 corrupt", 16'h0001, 1'b0);
    endtask

    task automatic t_idle();
        logic [W-1:0] m[8] = '{16'h1234, 16'hABCD, 0, 0, 0, 0, 0, 0};
        @(negedge clk);
        in_valid = 1'b1; in_word = m[0]; in_last = 1'b0; in_mode = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_word = 16'h5555 + 16'(i); in_last = 1'b1; in_mode = 1'b1;
            // R8
            check("R8 idle no done", 32'(done), 32'd0);
        end
        @(negedge clk);
        check("R8 idle no done", 32'(done), 32'd0);
        in_valid = 1'b1; in_word = m[1]; in_last = 1'b1; in_mode = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        expect_result("R8 gaps", 16'h41FE, 1'b0);
        repeat (2) @(negedge clk);
        // R12
        check("R12 hold csum", 32'(csum_out), 32'h41FE);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        in_valid = 1'b1; in_word = 16'h1234; in_last = 1'b0; in_mode = 1'b0;
        @(negedge clk);
        in_word = 16'hABCD; in_last = 1'b1;
        @(negedge clk);
        // R9: first result out while next message starts
        in_word = 16'h0F0F; in_last = 1'b1;
        check("R9 first done", 32'(done), 32'd1);
        check("R9 first csum", 32'(csum_out), 32'h41FE);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check("R9 second done", 32'(done), 32'd1);
        check("R9 second csum", 32'(csum_out), 32'hF0F0);
        @(negedge clk);
        check("R9 pulse ends", 32'(done), 32'd0);
    endtask

    task automatic t_width5();
        logic [4:0] m[5] = '{5'b00110, 5'b10001, 5'b11001, 5'b10111, 5'b10110};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            v5 = 1'b1; w5 = m[i]; l5 = (i == 3); m5 = 1'b0;
        end
        @(negedge clk);
        v5 = 1'b0; l5 = 1'b0;
        // R11
        check("R11 w5 done", 32'(d5), 32'd1);
        check("R11 w5 csum", 32'(c5), 32'b10110);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            v5 = 1'b1; w5 = m[i]; l5 = (i == 4); m5 = 1'b1;
        end
        @(negedge clk);
        v5 = 1'b0; l5 = 1'b0;
        check("R11 w5 check pass", 32'(p5), 32'd1);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_mode = 1'b0; in_word = '0;
        v5 = 1'b0; l5 = 1'b0; m5 = 1'b0; w5 = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_multi_gen();
        t_carry();
        t_single();
        t_corrupt();
        t_idle();
        t_back_to_back();
        t_width5();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule